// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge Stall

This block receives bytes as an I2C master once the bus has already been claimed and the slave addressed. Software works it through four byte-wide registers. Reading the data register in receive mode clocks in the next byte, so the first such read is a dummy that only starts the transfer. Received bits are sampled while SCL is high and shifted in MSB first. The byte is placed in the data register after the eighth clock.

With the stall mode on, the engine raises its event flag at the falling edge of the eighth SCL clock and then holds SCL low. Software can then choose the acknowledge value for this byte. Clearing the flag releases the ninth clock. With the stall mode off, the flag is raised at the rising edge of the ninth clock instead. A stop condition is produced on request. SCL and SDA are open-drain: each has an output-enable that pulls the line low and a separate sample input. Each SCL half-period lasts DIV+1 system clocks.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, both line enables are 0, irq_o is 0, CTRL (addr 0) reads 0x00, STAT (addr 1) reads 0x00 and DIV (addr 3) reads DIV_RST (4).
- R2: A read of DATA (addr 2) starts a byte only when CTRL.busy (bit 4) is 1, CTRL.tx_sel (bit 2) is 0 and the engine is idle. Any other DATA read produces no SCL edge. While busy and idle, SCL is held low. While not busy, SCL is released.
- R3: Each SCL high phase of a data bit lasts DIV+1 system clock cycles.
- R4: Bits are sampled during SCL high, MSB first. After the eighth clock, the byte reads back from DATA.
- R5: With CTRL.wait_en (bit 0) at 1, STAT.flag (bit 0) is set at the falling edge of the eighth clock. SCL then stays low with STAT.stall (bit 1) at 1 for as long as the flag stays 1. No second flag is raised for that byte.
- R6: Writing STAT with bit 0 at 0 during the stall clears the flag and lets the ninth clock run.
- R7: With wait_en at 0, the flag stays 0 through the eighth falling edge and is 1 at the rising edge of the ninth clock.
- R8: During the ninth clock, SDA is pulled low when CTRL.ack_val (bit 1) is 0 and released when it is 1. During the eight data clocks, SDA is never driven, and it changes only while SCL is low outside a stop.
- R9: Writing CTRL with busy=0 and tx_sel=1 while busy produces the enable sequence (scl_oe,sda_oe) = (1,0), (1,1), (0,1), (0,0). After that, busy reads 0.
- R10: irq_o is STAT.flag AND CTRL.irq_en (bit 3). Writing 1 to STAT bit 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The hardest state to reach is the stall: SCL parked low after exactly eight clocks with the flag up, while the acknowledge value is still open. The bench gets there by acting as a slave that counts SCL edges on the wires. It starts a byte with stall mode on, waits for the eighth falling edge, and then idles for many bit times. During that wait it checks that no ninth rising edge appears. Only then does it clear the flag and watch the level SDA carries on the ninth clock. The no-stall path is reached by changing the mode bit right after the read that starts the next byte, which is well before that byte's eighth clock.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BIT_LO, ST_BIT_HI, ST_WAIT, ST_ACK_LO, ST_ACK_HI,
    ST_STOP_LO, ST_STOP_HI, ST_STOP_REL
  } eng_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  localparam int CTRL_WAIT  = 0;
  localparam int CTRL_ACK   = 1;
  localparam int CTRL_TXSEL = 2;
  localparam int CTRL_IEN   = 3;
  localparam int CTRL_BUSY  = 4;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs import i2c_rx_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              eng_idle_i,
  input  logic              set_flag_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              stop_done_i,
  input  logic              wait_active_i,
  output logic              start_o,
  output logic              stop_req_o,
  output logic              busy_o,
  output logic              wait_en_o,
  output logic              ack_val_o,
  output logic              flag_o,
  output logic [DIV_W-1:0]  div_o
);
  logic              wait_en_q, ack_q, txsel_q, ien_q, busy_q, stop_req_q, flag_q;
  logic [BYTE_W-1:0] data_q;
  logic [DIV_W-1:0]  div_q;

  logic wr_ctrl, wr_stat;
  assign wr_ctrl = wr_en_i && addr_i == ADDR_CTRL;
  assign wr_stat = wr_en_i && addr_i == ADDR_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_en_q  <= 1'b0;
      ack_q      <= 1'b0;
      txsel_q    <= 1'b0;
      ien_q      <= 1'b0;
      busy_q     <= 1'b0;
      stop_req_q <= 1'b0;
      flag_q     <= 1'b0;
      data_q     <= '0;
      div_q      <= DIV_W'(DIV_RST);
    end else begin
      if (wr_ctrl) begin
        wait_en_q <= wdata_i[CTRL_WAIT];
        ack_q     <= wdata_i[CTRL_ACK];
        txsel_q   <= wdata_i[CTRL_TXSEL];
        ien_q     <= wdata_i[CTRL_IEN];
        if (wdata_i[CTRL_BUSY]) busy_q <= 1'b1;
        else if (busy_q && wdata_i[CTRL_TXSEL]) stop_req_q <= 1'b1;
      end
      if (stop_done_i) begin
        busy_q     <= 1'b0;
        stop_req_q <= 1'b0;
      end
      if (set_flag_i) flag_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) flag_q <= 1'b0;
      if (byte_valid_i) data_q <= byte_i;
      if (wr_en_i && addr_i == ADDR_DIV) div_q <= DIV_W'(wdata_i);
    end
  end

  // a data-register read in receive mode clocks in the next byte
  assign start_o = rd_en_i && addr_i == ADDR_DATA && !txsel_q && busy_q
                   && !stop_req_q && eng_idle_i;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {3'b000, busy_q, ien_q, txsel_q, ack_q, wait_en_q};
      ADDR_STAT: rdata_o = {6'b0, wait_active_i, flag_q};
      ADDR_DATA: rdata_o = data_q;
      default:   rdata_o = BYTE_W'(div_q);
    endcase
  end

  assign irq_o      = flag_q & ien_q;
  assign stop_req_o = stop_req_q;
  assign busy_o     = busy_q;
  assign wait_en_o  = wait_en_q;
  assign ack_val_o  = ack_q;
  assign flag_o     = flag_q;
  assign div_o      = div_q;

  assert_flag_write1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && flag_q) |=> flag_q);

  assert_busy_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(stop_req_q));
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine import i2c_rx_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic              stop_req_i,
  input  logic              busy_i,
  input  logic              wait_en_i,
  input  logic              ack_val_i,
  input  logic              flag_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              set_flag_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              stop_done_o,
  output logic              wait_active_o,
  output logic              idle_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  eng_state_e        state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, shreg_nxt;
  logic              stalled_q;
  logic              tick, timed, last_bit, smp, byte_done;

  assign tick     = cnt_q == div_i;
  assign timed    = state_q inside {ST_BIT_LO, ST_BIT_HI, ST_ACK_LO, ST_ACK_HI,
                                    ST_STOP_LO, ST_STOP_HI, ST_STOP_REL};
  assign last_bit = bit_cnt_q == BIT_W'(BYTE_W - 1);
  // one sample per high phase, taken once SCL is seen high
  assign smp       = state_q == ST_BIT_HI && cnt_q == '0 && scl_i;
  assign shreg_nxt = smp ? {shreg_q[BYTE_W-2:0], sda_i} : shreg_q;
  assign byte_done = state_q == ST_BIT_HI && tick && last_bit;

  assign set_flag_o    = (byte_done && wait_en_i) || (state_q == ST_ACK_LO && tick && !stalled_q);
  assign byte_valid_o  = byte_done;
  assign byte_o        = shreg_nxt;
  assign stop_done_o   = state_q == ST_STOP_REL && tick;
  assign wait_active_o = state_q == ST_WAIT;
  assign idle_o        = state_q == ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      stalled_q <= 1'b0;
    end else begin
      shreg_q <= shreg_nxt;
      if (timed) cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
      else       cnt_q <= '0;
      unique case (state_q)
        ST_IDLE:
          if (start_i) begin
            state_q   <= ST_BIT_LO;
            bit_cnt_q <= '0;
          end else if (stop_req_i && busy_i) begin
            state_q <= ST_STOP_LO;
          end
        ST_BIT_LO: if (tick) state_q <= ST_BIT_HI;
        ST_BIT_HI:
          if (tick) begin
            if (last_bit) begin
              stalled_q <= wait_en_i;
              state_q   <= wait_en_i ? ST_WAIT : ST_ACK_LO;
            end else begin
              bit_cnt_q <= bit_cnt_q + BIT_W'(1);
              state_q   <= ST_BIT_LO;
            end
          end
        ST_WAIT:     if (!flag_i) state_q <= ST_ACK_LO;
        ST_ACK_LO:   if (tick) state_q <= ST_ACK_HI;
        ST_ACK_HI:   if (tick) state_q <= ST_IDLE;
        ST_STOP_LO:  if (tick) state_q <= ST_STOP_HI;
        ST_STOP_HI:  if (tick) state_q <= ST_STOP_REL;
        ST_STOP_REL: if (tick) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_IDLE:                         scl_oe_o = busy_i;
      ST_BIT_LO, ST_WAIT:              scl_oe_o = 1'b1;
      ST_ACK_LO: begin                 scl_oe_o = 1'b1; sda_oe_o = !ack_val_i; end
      ST_ACK_HI:                       sda_oe_o = !ack_val_i;
      ST_STOP_LO: begin                scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      ST_STOP_HI:                      sda_oe_o = 1'b1;
      default: ;
    endcase
  end

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && flag_i) |=> state_q == ST_WAIT);

  assert_stall_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !flag_i) |=> state_q == ST_ACK_LO);
endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master import i2c_rx_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic       scl_i,
  output logic       scl_oe_o,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  logic              start, stop_req, busy, wait_en, ack_val, flag;
  logic              set_flag, byte_valid, stop_done, wait_active, eng_idle;
  logic [BYTE_W-1:0] rx_byte;
  logic [DIV_W-1:0]  div;

  i2c_rx_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o, .irq_o,
    .eng_idle_i(eng_idle), .set_flag_i(set_flag), .byte_valid_i(byte_valid),
    .byte_i(rx_byte), .stop_done_i(stop_done), .wait_active_i(wait_active),
    .start_o(start), .stop_req_o(stop_req), .busy_o(busy), .wait_en_o(wait_en),
    .ack_val_o(ack_val), .flag_o(flag), .div_o(div)
  );

  i2c_rx_engine #(.DIV_W(DIV_W)) u_engine (
    .clk_i, .rst_ni, .div_i(div), .start_i(start), .stop_req_i(stop_req),
    .busy_i(busy), .wait_en_i(wait_en), .ack_val_i(ack_val), .flag_i(flag),
    .scl_i, .sda_i, .scl_oe_o, .sda_oe_o, .set_flag_o(set_flag),
    .byte_valid_o(byte_valid), .byte_o(rx_byte), .stop_done_o(stop_done),
    .wait_active_o(wait_active), .idle_o(eng_idle)
  );

  // the flag only rises together with an SCL edge (8th fall or 9th rise)
  assert_flag_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> scl_oe_o != $past(scl_oe_o));

  // SDA moves only while SCL is low, except during a stop
  assert_sda_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && !$past(stop_req)) |-> $stable(sda_oe_o));
endmodule

// File: tb/test_i2c_rx_master.sv
module test_i2c_rx_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe;
  logic [7:0] slave_byte = 8'hFF;
  int         rise_cnt = 0, fall_cnt = 0;
  logic       irq_rise8, irq_fall8, irq_rise9, ack_drv;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  wire scl_line  = !scl_oe;
  wire slave_low = (fall_cnt < 8) && !slave_byte[3'(7 - fall_cnt)];
  wire sda_line  = !(sda_oe || slave_low);

  always #10 clk = ~clk;

  i2c_rx_master i_i2c_rx_master (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .scl_i(scl_line),
    .scl_oe_o(scl_oe), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  always @(posedge scl_line) begin
    rise_cnt++;
    #1;
    if (rise_cnt == 8) irq_rise8 = irq;
    if (rise_cnt == 9) begin irq_rise9 = irq; ack_drv = sda_oe; end
  end

  always @(negedge scl_line) begin
    fall_cnt++;
    #1;
    if (fall_cnt == 8) irq_fall8 = irq;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
    reg_rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    reg_rd(2'd1, d); chk("R1 stat", d, 8'h00);
    reg_rd(2'd3, d); chk("R1 div", d, 8'h04);
    reg_wr(2'd3, 8'h03);
  endtask

  task automatic t_ignored_read;
    logic [7:0] d;
    rise_cnt = 0;
    reg_rd(2'd2, d);
    repeat (40) @(negedge clk);
    chk("R2 no clock when not busy", rise_cnt, 0);
    chk("R2 scl released when not busy", scl_oe, 0);
    reg_wr(2'd0, 8'h14);            // busy=1, tx_sel=1
    rise_cnt = 0;
    reg_rd(2'd2, d);
    repeat (40) @(negedge clk);
    chk("R2 no clock with tx_sel", rise_cnt, 0);
    chk("R2 scl held low when busy", scl_oe, 1);
  endtask

  task automatic t_wait_byte;
    logic [7:0] d;
    int hi_len;
    reg_wr(2'd0, 8'h19);            // wait=1 ack=0 irq_en=1 busy=1
    slave_byte = 8'hA5; rise_cnt = 0; fall_cnt = 0;
    reg_rd(2'd2, d);                // dummy read starts the byte
    @(posedge scl_line);
    hi_len = 0;
    do begin @(posedge clk); #1; hi_len++; end while (scl_line);
    chk("R3 high phase length", hi_len, 4);
    wait (fall_cnt == 8);
    repeat (40) @(negedge clk);
    chk("R5 no 9th clock during stall", rise_cnt, 8);
    chk("R5 scl held low", scl_oe, 1);
    chk("R5 flag clear at 8th rise", irq_rise8, 0);
    chk("R5 flag set at 8th fall", irq_fall8, 1);
    reg_rd(2'd1, d); chk("R5 stat stall+flag", d, 8'h03);
    reg_wr(2'd1, 8'h00);
    wait (rise_cnt == 9); #2;
    chk("R6 ninth clock after clear", rise_cnt, 9);
    chk("R8 ack drives sda low", ack_drv, 1);
    chk("R5 no second flag", irq_rise9, 0);
    wait (fall_cnt == 9);
    repeat (3) @(negedge clk);
    chk("R5 irq low after byte", irq, 0);
  endtask

  task automatic t_nowait_byte;
    logic [7:0] d;
    slave_byte = 8'h3C; rise_cnt = 0; fall_cnt = 0;
    reg_rd(2'd2, d);
    chk("R4 first byte", d, 8'hA5);
    reg_wr(2'd0, 8'h1A);            // wait=0 ack=1 irq_en=1 busy=1
    wait (fall_cnt == 9);
    repeat (3) @(negedge clk);
    chk("R7 flag clear at 8th fall", irq_fall8, 0);
    chk("R7 flag set at 9th rise", irq_rise9, 1);
    chk("R7 no stall", rise_cnt, 9);
    chk("R8 nack releases sda", ack_drv, 0);
  endtask

  task automatic t_irq_flag;
    logic [7:0] d;
    reg_wr(2'd1, 8'h01);
    chk("R10 write 1 keeps flag", irq, 1);
    reg_wr(2'd0, 8'h12);            // irq_en=0
    chk("R10 irq masked", irq, 0);
    reg_rd(2'd1, d); chk("R10 flag still set", d, 8'h01);
    reg_wr(2'd1, 8'h00);
    reg_rd(2'd1, d); chk("R10 flag cleared", d, 8'h00);
  endtask

  task automatic t_stop;
    logic [7:0] d;
    int seq[6];
    int n;
    logic [1:0] prev, cur;
    reg_wr(2'd0, 8'h04);            // tx_sel=1 busy=0 -> stop
    prev = 2'b10; seq[0] = 2; n = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      cur = {scl_oe, sda_oe};
      if (cur != prev && n < 6) begin seq[n] = int'(cur); n++; end
      prev = cur;
    end
    chk("R9 stop step count", n, 4);
    chk("R9 step sda low", seq[1], 3);
    chk("R9 step scl release", seq[2], 1);
    chk("R9 step sda release", seq[3], 0);
    reg_rd(2'd0, d); chk("R9 busy clear", d, 8'h04);
  endtask

  task automatic t_after_stop;
    logic [7:0] d;
    rise_cnt = 0;
    reg_rd(2'd2, d);
    chk("R4 final byte", d, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R2 no clock after stop", rise_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ignored_read();
    t_wait_byte();
    t_nowait_byte();
    t_irq_flag();
    t_stop();
    t_after_stop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule